// File: doc/BRIEF.md
# Volume-Control Serial Register Slave

This block is the serial front end of a two-channel volume control. It watches an I2C bus through an oversampled system clock. It answers one 7-bit address, made of a fixed upper nibble and three strap pins. It turns each written byte into a write strobe for one of three registers, and it streams those registers back on a read. The registers live outside the block. It drives write strobes and a data byte to them, and it reads their present values from them to send back.

A written byte names its own target in its two top bits. That way one transaction can update either channel's wiper and the configuration, in any order. A read always begins with the first wiper. It then returns the second wiper and the configuration, and it wraps round for as long as the master keeps acknowledging. An active-low enable pin can cut the block off from the bus entirely. A busy input from the nonvolatile commit controller makes the block refuse its address, so the master can poll for completion.

Top module: `volpot_i2c_slave`

## Requirements
- R1: The block acknowledges an address byte whose upper seven bits equal binary 0101 followed by `addr_pins[2:0]`. It acknowledges by asserting `sda_oe` during the ninth clock. Bit 0 of the address byte selects read (1) or write (0).
- R2: After an address byte that does not match, the block never asserts `sda_oe` and raises no write strobe until the next START. This holds whether the upper nibble or the pin bits differ.
- R3: While `ce_n` is high, the block asserts neither `sda_oe` nor any write strobe, whatever happens on SCL and SDA.
- R4: In a write, a data byte with bits 7–6 = 00 pulses `wip0_we`, 01 pulses `wip1_we`, and 10 pulses `cfg_we`. Each pulse lasts one clock, and `wr_data` carries the whole byte during it. At most one strobe is high at a time.
- R5: A data byte with bits 7–6 = 11 raises no strobe but is still acknowledged.
- R6: One write transaction may carry any number of data bytes for any targets in any order. Each byte is acknowledged.
- R7: A read returns, MSB first, three bytes in order. The first is `{2'b00, wip0_q}` and the second is `{2'b01, wip1_q}`. The third is `{2'b10, 3'b000, cfg_q}`. Each field is zero-extended to fill bits 5–0.
- R8: After the configuration byte, an acknowledge from the master brings wiper 0 again, round-robin. After a NACK the block releases SDA and stays silent until the next START.
- R9: Every read transaction starts at wiper 0, however the previous read ended.
- R10: While `commit_busy` is high at the end of the address byte, the address is not acknowledged and the transaction is ignored.
- R11: A START in any state, including partway through a data byte, abandons the current byte and restarts address reception.
- R12: `sda_oe` is low out of reset and stays low except while the block sends an acknowledge or a zero data bit. It never changes while SCL is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversampling the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | Pull SDA low when high (open-drain enable) |
| addr_pins | input | 3 | Strap pins forming the low three address bits |
| ce_n | input | 1 | Active-low bus enable |
| commit_busy | input | 1 | Nonvolatile commit in progress |
| wip0_we | output | 1 | Write strobe, wiper 0 |
| wip1_we | output | 1 | Write strobe, wiper 1 |
| cfg_we | output | 1 | Write strobe, configuration |
| wr_data | output | 8 | Received command byte accompanying a strobe |
| wip0_q | input | WIPER_W | Current wiper 0 value for readback |
| wip1_q | input | WIPER_W | Current wiper 1 value for readback |
| cfg_q | input | CFG_W | Current configuration value for readback |

## Verification
The bench sends reserved-selector bytes inside a multi-byte write. A decoder that treats 11 as a target would raise a stray strobe, and one that withholds the acknowledge would stall the master. It reads seven bytes in a row and then starts a fresh read after one that stopped on wiper 1. A pointer that fails to wrap or fails to rewind would return the wrong tag in bits 7–6. It also aborts a data byte with a repeated START, and it addresses the block while busy, while disabled and with wrong address bits. A slave that kept stale bit counts, ignored busy or leaked through the enable would acknowledge or strobe where the scoreboard expects silence.

// File: rtl/volpot_pkg.sv
package volpot_pkg;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_RX   = 3'd1,
      ST_ACK  = 3'd2,
      ST_TX   = 3'd3,
      ST_MACK = 3'd4
   } bus_st_e;

   // target selector carried in bits 7..6 of a command byte
   localparam logic [1:0] SEL_W0  = 2'b00;
   localparam logic [1:0] SEL_W1  = 2'b01;
   localparam logic [1:0] SEL_CFG = 2'b10;

   localparam int NUM_READ_REGS = 3;

   function automatic logic [1:0] rd_ptr_next(input logic [1:0] p);
      return (p == 2'(NUM_READ_REGS - 1)) ? 2'd0 : p + 2'd1;
   endfunction

endpackage

// File: rtl/volpot_sync.sv
module volpot_sync #(
   parameter int             W       = 1,
   parameter int             STAGES  = 2,
   parameter logic [W-1:0]   RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("volpot_sync: STAGES must be at least 2");
   end

   for (genvar g = 0; g < W; g++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= {STAGES{RST_VAL[g]}};
         else        chain <= {chain[STAGES-2:0], d[g]};
      end
      assign q[g] = chain[STAGES-1];
   end

endmodule

// File: rtl/volpot_edge.sv
module volpot_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic scl_s,
   input  logic sda_s,
   output logic scl_q,
   output logic ev_rise,
   output logic ev_fall,
   output logic ev_start,
   output logic ev_stop
);

   logic sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   assign ev_rise  = en &  scl_s & ~scl_q;
   assign ev_fall  = en & ~scl_s &  scl_q;
   assign ev_start = en &  scl_s &  scl_q &  sda_q & ~sda_s;
   assign ev_stop  = en &  scl_s &  scl_q & ~sda_q &  sda_s;

endmodule

// File: rtl/volpot_cmd_dec.sv
module volpot_cmd_dec
   import volpot_pkg::*;
(
   input  logic       fire,
   input  logic [1:0] sel,
   output logic       we_w0,
   output logic       we_w1,
   output logic       we_cfg
);

   always_comb begin
      we_w0  = 1'b0;
      we_w1  = 1'b0;
      we_cfg = 1'b0;
      if (fire) begin
         case (sel)
            SEL_W0:  we_w0  = 1'b1;
            SEL_W1:  we_w1  = 1'b1;
            SEL_CFG: we_cfg = 1'b1;
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/volpot_rd_fmt.sv
module volpot_rd_fmt
   import volpot_pkg::*;
#(
   parameter int WIPER_W = 6,
   parameter int CFG_W   = 3
) (
   input  logic [1:0]         sel,
   input  logic [WIPER_W-1:0] w0,
   input  logic [WIPER_W-1:0] w1,
   input  logic [CFG_W-1:0]   cfg,
   output logic [7:0]         tx_byte
);

   logic [5:0] f_w0, f_w1, f_cfg;

   assign f_w0  = 6'(w0);
   assign f_w1  = 6'(w1);
   assign f_cfg = 6'(cfg);

   always_comb begin
      case (sel)
         2'd0:    tx_byte = {SEL_W0,  f_w0};
         2'd1:    tx_byte = {SEL_W1,  f_w1};
         default: tx_byte = {SEL_CFG, f_cfg};
      endcase
   end

endmodule

// File: rtl/volpot_i2c_slave.sv
module volpot_i2c_slave
   import volpot_pkg::*;
#(
   parameter int         SYNC_STAGES = 2,
   parameter logic [3:0] ADDR_HI     = 4'b0101,
   parameter int         WIPER_W     = 6,
   parameter int         CFG_W       = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               scl_i,
   input  logic               sda_i,
   output logic               sda_oe,
   input  logic [2:0]         addr_pins,
   input  logic               ce_n,
   input  logic               commit_busy,
   output logic               wip0_we,
   output logic               wip1_we,
   output logic               cfg_we,
   output logic [7:0]         wr_data,
   input  logic [WIPER_W-1:0] wip0_q,
   input  logic [WIPER_W-1:0] wip1_q,
   input  logic [CFG_W-1:0]   cfg_q
);

   localparam int SEL_BITS = 2;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("volpot_i2c_slave: SYNC_STAGES must be at least 2");
   end
   if (WIPER_W < 1 || WIPER_W > 8 - SEL_BITS) begin : g_bad_wiper
      $error("volpot_i2c_slave: WIPER_W must fit below the selector bits");
   end
   if (CFG_W < 1 || CFG_W > 8 - SEL_BITS) begin : g_bad_cfg
      $error("volpot_i2c_slave: CFG_W must fit below the selector bits");
   end

   // ---------------- input conditioning ----------------
   logic [2:0] raw_in, syn_in;
   logic       ce_off, scl_s, sda_s, scl_q;
   logic       ev_rise, ev_fall, ev_start, ev_stop;

   assign raw_in = {ce_n, scl_i, sda_i};

   volpot_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_in),
      .q     (syn_in)
   );

   assign ce_off = syn_in[2];
   assign scl_s  = syn_in[1];
   assign sda_s  = syn_in[0];

   volpot_edge i_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (~ce_off),
      .scl_s    (scl_s),
      .sda_s    (sda_s),
      .scl_q    (scl_q),
      .ev_rise  (ev_rise),
      .ev_fall  (ev_fall),
      .ev_start (ev_start),
      .ev_stop  (ev_stop)
   );

   // ---------------- byte engine ----------------
   bus_st_e    state;
   logic [2:0] bitcnt;
   logic       byte_full;
   logic       is_addr;
   logic       rd_mode;
   logic       mack_nack;
   logic [7:0] shreg;
   logic [7:0] txsh;
   logic [1:0] rd_ptr;
   logic [1:0] ptr_next;
   logic [1:0] tx_sel;
   logic [7:0] tx_byte;
   logic       addr_hit;
   logic       cmd_fire;
   logic       ack_addr;

   assign ptr_next = rd_ptr_next(rd_ptr);
   assign tx_sel   = (state == ST_MACK) ? ptr_next : rd_ptr;
   assign addr_hit = (shreg[7:1] == {ADDR_HI, addr_pins}) && !commit_busy;
   assign cmd_fire = (state == ST_RX) && ev_fall && byte_full && !is_addr;
   assign ack_addr = (state == ST_ACK) && is_addr;

   volpot_rd_fmt #(.WIPER_W(WIPER_W), .CFG_W(CFG_W)) i_fmt (
      .sel     (tx_sel),
      .w0      (wip0_q),
      .w1      (wip1_q),
      .cfg     (cfg_q),
      .tx_byte (tx_byte)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         bitcnt    <= '0;
         byte_full <= 1'b0;
         is_addr   <= 1'b0;
         rd_mode   <= 1'b0;
         mack_nack <= 1'b1;
         shreg     <= '0;
         txsh      <= 8'hFF;
         rd_ptr    <= '0;
      end else if (ce_off) begin
         state     <= ST_IDLE;
         byte_full <= 1'b0;
      end else if (ev_start) begin
         state     <= ST_RX;
         is_addr   <= 1'b1;
         bitcnt    <= '0;
         byte_full <= 1'b0;
      end else if (ev_stop) begin
         state     <= ST_IDLE;
         byte_full <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: ;
            ST_RX: begin
               if (ev_rise) begin
                  shreg  <= {shreg[6:0], sda_s};
                  bitcnt <= bitcnt + 3'd1;
                  if (bitcnt == 3'd7) byte_full <= 1'b1;
               end else if (ev_fall && byte_full) begin
                  byte_full <= 1'b0;
                  if (is_addr) begin
                     if (addr_hit) begin
                        state   <= ST_ACK;
                        rd_mode <= shreg[0];
                        rd_ptr  <= '0;
                     end else begin
                        state <= ST_IDLE;
                     end
                  end else begin
                     state <= ST_ACK;
                  end
               end
            end
            ST_ACK: begin
               if (ev_fall) begin
                  bitcnt <= '0;
                  if (rd_mode) begin
                     state <= ST_TX;
                     txsh  <= tx_byte;
                  end else begin
                     state   <= ST_RX;
                     is_addr <= 1'b0;
                  end
               end
            end
            ST_TX: begin
               if (ev_fall) begin
                  bitcnt <= bitcnt + 3'd1;
                  txsh   <= {txsh[6:0], 1'b1};
                  if (bitcnt == 3'd7) state <= ST_MACK;
               end
            end
            ST_MACK: begin
               if (ev_rise) begin
                  mack_nack <= sda_s;
               end else if (ev_fall) begin
                  if (!mack_nack) begin
                     rd_ptr <= ptr_next;
                     txsh   <= tx_byte;
                     bitcnt <= '0;
                     state  <= ST_TX;
                  end else begin
                     state <= ST_IDLE;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign sda_oe = (state == ST_ACK) || ((state == ST_TX) && !txsh[7]);

   // ---------------- command decode ----------------
   volpot_cmd_dec i_dec (
      .fire   (cmd_fire),
      .sel    (shreg[7:6]),
      .we_w0  (wip0_we),
      .we_w1  (wip1_we),
      .we_cfg (cfg_we)
   );

   assign wr_data = shreg;

endmodule

// File: rtl/volpot_i2c_chk.sv
module volpot_i2c_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       ce_off,
   input logic       scl_s,
   input logic       scl_q,
   input logic       sda_oe,
   input logic       wip0_we,
   input logic       wip1_we,
   input logic       cfg_we,
   input logic [7:0] wr_data,
   input logic       commit_busy,
   input logic       ack_addr
);

   // R3: a disabled bus produces no drive and no strobe
   a_r3_ce_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (ce_off && $past(ce_off)) |-> (!sda_oe && !wip0_we && !wip1_we && !cfg_we));

   // R4: strobes are mutually exclusive
   a_r4_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({wip0_we, wip1_we, cfg_we}));

   // R4: a strobe carries a byte whose selector names its target
   a_r4_strobe_tag: assert property (@(posedge clk) disable iff (!rst_n)
      (wip0_we |-> wr_data[7:6] == 2'b00) and
      (wip1_we |-> wr_data[7:6] == 2'b01) and
      (cfg_we  |-> wr_data[7:6] == 2'b10));

   // R10: an address acknowledge begins only when the commit was idle
   a_r10_busy_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack_addr) |-> !$past(commit_busy));

   // R12: the data line enable holds steady across a high SCL phase
   a_r12_oe_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_s && scl_q && !ce_off && !$past(ce_off)) |-> $stable(sda_oe));

endmodule

bind volpot_i2c_slave volpot_i2c_chk i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .ce_off      (ce_off),
   .scl_s       (scl_s),
   .scl_q       (scl_q),
   .sda_oe      (sda_oe),
   .wip0_we     (wip0_we),
   .wip1_we     (wip1_we),
   .cfg_we      (cfg_we),
   .wr_data     (wr_data),
   .commit_busy (commit_busy),
   .ack_addr    (ack_addr)
);

// File: tb/test_volpot_i2c_slave.sv
`timescale 1ns/1ps
module test_volpot_i2c_slave;

   localparam int H = 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_m = 1'b1;
   logic       sda_m = 1'b1;
   logic       ce_n = 1'b0;
   logic       busy = 1'b0;
   logic [2:0] pins = 3'b101;

   logic       sda_oe, wip0_we, wip1_we, cfg_we;
   logic [7:0] wr_data;
   logic [5:0] r_w0 = '0, r_w1 = '0;
   logic [2:0] r_cfg = '0;

   wire sda_line = sda_m & ~sda_oe;

   always #2 clk = ~clk;

   volpot_i2c_slave i_volpot_i2c_slave (
      .clk         (clk),
      .rst_n       (rst_n),
      .scl_i       (scl_m),
      .sda_i       (sda_line),
      .sda_oe      (sda_oe),
      .addr_pins   (pins),
      .ce_n        (ce_n),
      .commit_busy (busy),
      .wip0_we     (wip0_we),
      .wip1_we     (wip1_we),
      .cfg_we      (cfg_we),
      .wr_data     (wr_data),
      .wip0_q      (r_w0),
      .wip1_q      (r_w1),
      .cfg_q       (r_cfg)
   );

   // register file in the environment, written by the strobes
   always @(posedge clk) begin
      if (wip0_we) r_w0  <= wr_data[5:0];
      if (wip1_we) r_w1  <= wr_data[5:0];
      if (cfg_we)  r_cfg <= wr_data[2:0];
   end

   int n_chk = 0, n_fail = 0, n_strobe = 0;
   logic [9:0] exp_q[$];
   bit done = 1'b0;

   task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   // scoreboard monitor: every strobe must match the next expected item (R4)
   always @(negedge clk) begin
      if (rst_n && (wip0_we || wip1_we || cfg_we)) begin
         logic [1:0] k;
         logic [9:0] e;
         k = wip1_we ? 2'd1 : (cfg_we ? 2'd2 : 2'd0);
         n_strobe++;
         if (exp_q.size() == 0) begin
            n_chk++;
            n_fail++;
            $display("FAIL R4: unexpected strobe got %h expected none", {k, wr_data});
         end else begin
            e = exp_q.pop_front();
            check("R4 strobe target/data", 16'({k, wr_data}), 16'(e));
         end
      end
   end

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; wait_clk(H);
      scl_m = 1'b1; wait_clk(H);
      sda_m = 1'b0; wait_clk(H);
      scl_m = 1'b0; wait_clk(H);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; wait_clk(H);
      scl_m = 1'b1; wait_clk(H);
      sda_m = 1'b1; wait_clk(H);
   endtask

   task automatic xfer_bit(input logic b, output logic r);
      sda_m = b;    wait_clk(H);
      scl_m = 1'b1; wait_clk(H/2);
      r = sda_line; wait_clk(H/2);
      scl_m = 1'b0;
   endtask

   task automatic wr_byte(input logic [7:0] b, output logic ack);
      logic r;
      for (int i = 7; i >= 0; i--) xfer_bit(b[i], r);
      xfer_bit(1'b1, r);
      ack = ~r;
   endtask

   task automatic rd_byte(input logic ack_it, output logic [7:0] b);
      logic r;
      for (int i = 7; i >= 0; i--) begin
         xfer_bit(1'b1, r);
         b[i] = r;
      end
      xfer_bit(~ack_it, r);
   endtask

   task automatic push_cmd(input logic [7:0] c);
      if (c[7:6] != 2'b11) exp_q.push_back({c[7:6], c});
   endtask

   task automatic summary();
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
   endtask

   initial begin
      wait_clk(150000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: run did not complete, got timeout expected completion");
         summary();
         $finish;
      end
   end

   localparam logic [7:0] A_WR = 8'h5A;
   localparam logic [7:0] A_RD = 8'h5B;

   initial begin
      logic ack;
      logic [7:0] b;
      int s0;
      logic [7:0] exp_rd [3];
      logic [7:0] cmds [4];

      wait_clk(10);
      check("R12 reset drive", 16'(sda_oe), 16'd0);
      check("R12 reset strobes", 16'({wip0_we, wip1_we, cfg_we}), 16'd0);
      rst_n = 1'b1;
      wait_clk(10);

      // R1 / R4: single command to wiper 0
      bus_start();
      wr_byte(A_WR, ack);  check("R1 address ack", 16'(ack), 16'd1);
      push_cmd(8'h15);
      wr_byte(8'h15, ack); check("R4 data ack", 16'(ack), 16'd1);
      bus_stop();

      // R6 / R5: several commands, mixed order, one reserved
      cmds = '{8'h6A, 8'h85, 8'hC7, 8'h3F};
      bus_start();
      wr_byte(A_WR, ack);  check("R1 address ack", 16'(ack), 16'd1);
      for (int i = 0; i < 4; i++) begin
         s0 = n_strobe;
         push_cmd(cmds[i]);
         wr_byte(cmds[i], ack);
         check(i == 2 ? "R5 reserved ack" : "R6 multi ack", 16'(ack), 16'd1);
         if (i == 2) begin
            wait_clk(4);
            check("R5 reserved no strobe", 16'(n_strobe - s0), 16'd0);
         end
      end
      bus_stop();
      check("R4 all strobes seen", 16'(exp_q.size()), 16'd0);

      // R7 / R8: seven-byte read wraps round
      exp_rd = '{8'h3F, 8'h6A, 8'h85};
      bus_start();
      wr_byte(A_RD, ack);  check("R1 read address ack", 16'(ack), 16'd1);
      for (int i = 0; i < 7; i++) begin
         rd_byte(i < 6, b);
         check(i < 3 ? "R7 read order" : "R8 round robin", 16'(b), 16'(exp_rd[i % 3]));
      end
      wait_clk(8);
      check("R8 released after nack", 16'(sda_oe), 16'd0);
      bus_stop();

      // R9: read that stops on wiper 1, then a fresh read
      bus_start();
      wr_byte(A_RD, ack);
      rd_byte(1'b1, b); rd_byte(1'b0, b);
      check("R7 second byte", 16'(b), 16'h006A);
      bus_stop();
      bus_start();
      wr_byte(A_RD, ack);
      rd_byte(1'b0, b);
      check("R9 restart at wiper 0", 16'(b), 16'h003F);
      bus_stop();

      // R2: wrong pin bits, then wrong upper nibble
      s0 = n_strobe;
      bus_start();
      wr_byte(8'h54, ack); check("R2 pin mismatch no ack", 16'(ack), 16'd0);
      wr_byte(8'h2A, ack); check("R2 data ignored", 16'(ack), 16'd0);
      bus_stop();
      bus_start();
      wr_byte(8'h7A, ack); check("R2 nibble mismatch no ack", 16'(ack), 16'd0);
      wr_byte(8'h01, ack); check("R2 data ignored", 16'(ack), 16'd0);
      bus_stop();
      bus_start();
      wr_byte(8'h55, ack); check("R2 read mismatch no ack", 16'(ack), 16'd0);
      rd_byte(1'b0, b);    check("R2 line left high", 16'(b), 16'h00FF);
      bus_stop();
      check("R2 no strobe", 16'(n_strobe - s0), 16'd0);

      // R3: enable high cuts the block off
      ce_n = 1'b1;
      wait_clk(8);
      s0 = n_strobe;
      bus_start();
      wr_byte(A_WR, ack);  check("R3 disabled no ack", 16'(ack), 16'd0);
      wr_byte(8'h01, ack); check("R3 disabled no data ack", 16'(ack), 16'd0);
      bus_stop();
      check("R3 no strobe", 16'(n_strobe - s0), 16'd0);
      ce_n = 1'b0;
      wait_clk(8);

      // R10: busy commit refuses the address
      busy = 1'b1;
      s0 = n_strobe;
      bus_start();
      wr_byte(A_WR, ack);  check("R10 busy no ack", 16'(ack), 16'd0);
      wr_byte(8'h22, ack); check("R10 busy data ignored", 16'(ack), 16'd0);
      bus_stop();
      check("R10 no strobe while busy", 16'(n_strobe - s0), 16'd0);
      busy = 1'b0;
      bus_start();
      wr_byte(A_WR, ack);  check("R10 ack after busy", 16'(ack), 16'd1);
      push_cmd(8'h0C);
      wr_byte(8'h0C, ack);
      bus_stop();

      // R11: repeated START partway through a data byte
      s0 = n_strobe;
      bus_start();
      wr_byte(A_WR, ack);
      xfer_bit(1'b0, ack); xfer_bit(1'b1, ack); xfer_bit(1'b0, ack);
      bus_start();
      wr_byte(A_WR, ack);  check("R11 address after restart", 16'(ack), 16'd1);
      push_cmd(8'h47);
      wr_byte(8'h47, ack); check("R11 data ack", 16'(ack), 16'd1);
      bus_stop();
      check("R11 only one strobe", 16'(n_strobe - s0), 16'd1);

      exp_rd = '{8'h0C, 8'h47, 8'h85};
      bus_start();
      wr_byte(A_RD, ack);
      for (int i = 0; i < 3; i++) begin
         rd_byte(i < 2, b);
         check("R11 readback after restart", 16'(b), 16'(exp_rd[i]));
      end
      bus_stop();

      wait_clk(10);
      check("R4 scoreboard drained", 16'(exp_q.size()), 16'd0);
      check("R12 idle release", 16'(sda_oe), 16'd0);

      done = 1'b1;
      summary();
      $finish;
   end

endmodule